// File: doc/BRIEF.md
# Scan-Accessed Debug Register Bank

This block is a bank of debug registers that a debugger reaches through one data-register scan chain of a JTAG test port. Each scan moves a 38-bit frame through the chain, least significant bit first. The low 32 bits carry a data word. The next 5 bits carry a register address. The top bit is a write flag. An external TAP controller supplies one-cycle capture, shift and update strobes on the block clock.

A frame with the write flag set stores its data word into the addressed register when the update strobe arrives. A frame with the flag clear only selects an address. The bank latches that register's value at update time, and the value comes back in the data field of the next scan. So a read always costs two scans, and the second scan is free to select the next address.

The bank holds these registers:

- a 6-bit debug control register
- a read-only 5-bit debug status that mirrors a core input
- an 8-bit vector-catch register
- two watchpoint units, each with six value and mask registers
- a two-way comms channel to the core

The core side of the comms channel is a valid/ready pair for each direction. Selecting the comms data register for a read takes the pending core word out of the channel. A debugger that selects that address twice in a row therefore consumes two words.

Top module: `dbg_regbank`

## Requirements
- R1: The chain is 38 bits and shifts least significant bit first: `tdo` presents chain bit 0, and each shift strobe moves `tdi` into bit 37. Frame layout: bits 31:0 are data, bits 36:32 are the address, bit 37 is the write flag.
- R2: An update strobe with the write flag at 1 stores the data into the addressed register. Debug control lives at address 0x00, is 6 bits wide and drives `dbg_ctrl_q`. Any of its bits, bit 4 included, can be cleared by a write.
- R3: An update strobe with the flag at 0 latches the value of the addressed register. The next capture strobe loads that value into chain bits 31:0 and zero into bits 37:32. Write scans leave the latched value unchanged.
- R4: Comms control sits at address 0x04 and is read-only. It reads as {VERSION[3:0] in bits 31:28, zeros in bits 27:2, the debugger-to-core pending flag in bit 1, the core-to-debugger ready flag in bit 0}.
- R5: A write to comms data at 0x05 puts the word on `core_rd_data` and raises `core_rd_valid`. A pulse on `core_rd_ack` clears it.
- R6: `core_wr_ready` is high while no core word is pending. A core write accepted in that state sets the ready flag. A core write offered while a word is pending is ignored.
- R7: Selecting address 0x05 for a read returns the pending core word on the next scan and clears the ready flag. Each further selection of 0x05 consumes whatever word is pending at that time.
- R8: Unused addresses read as zero and ignore writes. Debug status at 0x01 reads `dbg_status_in` and ignores writes.
- R9: Watchpoint 0 occupies 0x08 to 0x0D and watchpoint 1 occupies 0x10 to 0x15, in the order address value, address mask, data value, data mask, control value, control mask. Each register drives 32 bits of `wp_cfg`, at bit offset (unit*6+slot)*32.
- R10: After reset, all registers, both comms flags, the latched read value and the chain are zero.
- R11: Bits above a register's width read as zero. Widths are: control 6, status 5, vector catch 8 at address 0x02, watchpoint control value and mask 9, all other watchpoint registers 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | Capture strobe from the TAP |
| shift_en | input | 1 | Shift strobe from the TAP |
| update_en | input | 1 | Update strobe from the TAP |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of the chain |
| dbg_status_in | input | 5 | Core debug status |
| dbg_ctrl_q | output | 6 | Debug control register |
| vcatch_q | output | 8 | Vector-catch register |
| wp_cfg | output | 384 | All watchpoint registers, flattened |
| core_wr_valid | input | 1 | Core offers a word to the debugger |
| core_wr_data | input | 32 | Word from the core |
| core_wr_ready | output | 1 | Channel toward the debugger is empty |
| core_rd_valid | output | 1 | Debugger word waiting for the core |
| core_rd_data | output | 32 | Word for the core |
| core_rd_ack | input | 1 | Core has taken the word |

## Verification
The bench targets the two-scan read pipeline. A design that captured the current address instead of the latched one would return the read data one scan early, or would return the address field in place of data. The double consume of comms data is exercised on purpose: a design that consumed only on capture, or only once, would leave `core_wr_ready` low or would return a stale word. Writes to unused addresses and to status are followed by readbacks of neighbouring registers, because a broken address decoder would corrupt them. Random watchpoint writes check both the address map and the narrowed control fields.

// File: rtl/dbg_regbank_pkg.sv
package dbg_regbank_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int CHAIN_W = DATA_W + ADDR_W + 1;
  localparam int WP_SLOTS = 6;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'h01;
  localparam logic [ADDR_W-1:0] A_VCAT  = 5'h02;
  localparam logic [ADDR_W-1:0] A_CCTL  = 5'h04;
  localparam logic [ADDR_W-1:0] A_CDAT  = 5'h05;

  typedef struct packed {
    logic                wr;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
  } frame_t;

  function automatic logic [ADDR_W-1:0] wp_addr(input int unit, input int slot);
    return ADDR_W'((unit + 1) * 8 + slot);
  endfunction
endpackage

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
  import dbg_regbank_pkg::*;
#(
  parameter int W = CHAIN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture_en,
  input  logic         shift_en,
  input  logic         tdi,
  input  logic [W-1:0] cap_word,
  output logic         tdo,
  output logic [W-1:0] chain_q
);
  logic [W-1:0] sr_q, sr_d;
  logic         sr_en;

  assign sr_en = capture_en | shift_en;

  always_comb begin
    sr_d = sr_q;
    if (capture_en)    sr_d = cap_word;
    else if (shift_en) sr_d = {tdi, sr_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign tdo     = sr_q[0];
  assign chain_q = sr_q;

  AST_SHIFT_LSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !capture_en) |=> (sr_q[W-2:0] == $past(sr_q[W-1:1]) && sr_q[W-1] == $past(tdi))); // R1
  AST_CAPTURE_HDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (sr_q[W-1:DATA_W] == '0)); // R3
endmodule

// File: rtl/dbg_comms.sv
module dbg_comms
  import dbg_regbank_pkg::*;
#(
  parameter logic [3:0] VERSION = 4'h6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_wr_en,
  input  logic [DATA_W-1:0] dbg_wr_data,
  input  logic              dbg_consume,
  input  logic              core_wr_valid,
  input  logic [DATA_W-1:0] core_wr_data,
  output logic              core_wr_ready,
  output logic              core_rd_valid,
  output logic [DATA_W-1:0] core_rd_data,
  input  logic              core_rd_ack,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [DATA_W-1:0] up_word
);
  logic              rdy_q, rdy_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] up_q, up_d;
  logic [DATA_W-1:0] down_q, down_d;
  logic              accept;

  assign accept = core_wr_valid & ~rdy_q;

  always_comb begin
    rdy_d  = rdy_q;
    up_d   = up_q;
    pend_d = pend_q;
    down_d = down_q;
    if (accept) begin
      rdy_d = 1'b1;
      up_d  = core_wr_data;
    end else if (dbg_consume) begin
      rdy_d = 1'b0;
    end
    if (dbg_wr_en) begin
      pend_d = 1'b1;
      down_d = dbg_wr_data;
    end else if (core_rd_ack) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      pend_q <= 1'b0;
      up_q   <= '0;
      down_q <= '0;
    end else begin
      rdy_q  <= rdy_d;
      pend_q <= pend_d;
      if (accept)    up_q   <= up_d;
      if (dbg_wr_en) down_q <= down_d;
    end
  end

  assign core_wr_ready = ~rdy_q;
  assign core_rd_valid = pend_q;
  assign core_rd_data  = down_q;
  assign up_word       = up_q;
  assign ctrl_word     = {VERSION, {(DATA_W-6){1'b0}}, pend_q, rdy_q};

  AST_ACCEPT_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_valid && core_wr_ready) |=> !core_wr_ready); // R6
  AST_FULL_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_wr_ready && !dbg_consume) |=> (!core_wr_ready && $stable(up_word))); // R6
  AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_consume && !core_wr_valid) |=> core_wr_ready); // R7
  AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd_ack && !dbg_wr_en) |=> !core_rd_valid); // R5
endmodule

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
  import dbg_regbank_pkg::*;
#(
  parameter int CTRL_W = 6,
  parameter int STAT_W = 5,
  parameter int VC_W   = 8,
  parameter int NUM_WP = 2,
  parameter int WPC_W  = 9,
  localparam int NREG  = NUM_WP * WP_SLOTS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  input  logic [STAT_W-1:0]        status_in,
  output logic [CTRL_W-1:0]        ctrl_q,
  output logic [VC_W-1:0]          vcatch_q,
  output logic [NREG*DATA_W-1:0]   wp_flat
);
  logic [CTRL_W-1:0] ctrl_r, ctrl_d;
  logic [VC_W-1:0]   vc_r, vc_d;
  logic              ctrl_we, vc_we;
  logic [DATA_W-1:0] wp_r [NREG];

  assign ctrl_we = wr_en && (wr_addr == A_CTRL);
  assign vc_we   = wr_en && (wr_addr == A_VCAT);
  assign ctrl_d  = wr_data[CTRL_W-1:0];
  assign vc_d    = wr_data[VC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      vc_r   <= '0;
    end else begin
      if (ctrl_we) ctrl_r <= ctrl_d;
      if (vc_we)   vc_r   <= vc_d;
    end
  end

  for (genvar u = 0; u < NUM_WP; u++) begin : g_unit
    for (genvar s = 0; s < WP_SLOTS; s++) begin : g_slot
      localparam int IDX = u * WP_SLOTS + s;
      localparam int FW  = (s >= 4) ? WPC_W : DATA_W;
      localparam logic [ADDR_W-1:0] SA = wp_addr(u, s);
      localparam logic [DATA_W-1:0] MASK = (FW == DATA_W) ? {DATA_W{1'b1}}
                                         : DATA_W'((64'd1 << FW) - 64'd1);
      logic              we;
      logic [DATA_W-1:0] d;
      assign we = wr_en && (wr_addr == SA);
      assign d  = wr_data & MASK;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  wp_r[IDX] <= '0;
        else if (we) wp_r[IDX] <= d;
      end
      assign wp_flat[IDX*DATA_W +: DATA_W] = wp_r[IDX];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) rd_data = DATA_W'(ctrl_r);
    if (rd_addr == A_STAT) rd_data = DATA_W'(status_in);
    if (rd_addr == A_VCAT) rd_data = DATA_W'(vc_r);
    for (int u = 0; u < NUM_WP; u++) begin
      for (int s = 0; s < WP_SLOTS; s++) begin
        if (rd_addr == wp_addr(u, s)) rd_data = wp_r[u*WP_SLOTS + s];
      end
    end
  end

  assign ctrl_q   = ctrl_r;
  assign vcatch_q = vc_r;

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL) |=> (ctrl_q == $past(wr_data[CTRL_W-1:0]))); // R2
  AST_UNUSED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 5'h03 || wr_addr == A_STAT)) |=> ($stable(ctrl_q) && $stable(vcatch_q) && $stable(wp_flat))); // R8
endmodule

// File: rtl/dbg_regbank.sv
module dbg_regbank
  import dbg_regbank_pkg::*;
#(
  parameter logic [3:0] VERSION = 4'h6,
  parameter int CTRL_W = 6,
  parameter int STAT_W = 5,
  parameter int VC_W   = 8,
  parameter int NUM_WP = 2,
  parameter int WPC_W  = 9
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                capture_en,
  input  logic                                shift_en,
  input  logic                                update_en,
  input  logic                                tdi,
  output logic                                tdo,
  input  logic [STAT_W-1:0]                   dbg_status_in,
  output logic [CTRL_W-1:0]                   dbg_ctrl_q,
  output logic [VC_W-1:0]                     vcatch_q,
  output logic [NUM_WP*WP_SLOTS*DATA_W-1:0]   wp_cfg,
  input  logic                                core_wr_valid,
  input  logic [DATA_W-1:0]                   core_wr_data,
  output logic                                core_wr_ready,
  output logic                                core_rd_valid,
  output logic [DATA_W-1:0]                   core_rd_data,
  input  logic                                core_rd_ack
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [CHAIN_W-1:0] chain_q, cap_word;
  frame_t             frm;
  logic               wr_fire, sel_fire;
  logic [DATA_W-1:0]  hold_q, hold_d;
  logic [DATA_W-1:0]  regs_rd, comms_ctl, comms_up, rd_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cap_word = {{(CHAIN_W-DATA_W){1'b0}}, hold_q};

  dbg_scan_chain #(.W(CHAIN_W)) u_chain (
    .clk(clk), .rst_n(rst_int_n), .capture_en(capture_en), .shift_en(shift_en),
    .tdi(tdi), .cap_word(cap_word), .tdo(tdo), .chain_q(chain_q)
  );

  assign frm      = frame_t'(chain_q);
  assign wr_fire  = update_en &  frm.wr;
  assign sel_fire = update_en & ~frm.wr;

  dbg_ctrl_regs #(
    .CTRL_W(CTRL_W), .STAT_W(STAT_W), .VC_W(VC_W), .NUM_WP(NUM_WP), .WPC_W(WPC_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_fire), .wr_addr(frm.addr),
    .wr_data(frm.data), .rd_addr(frm.addr), .rd_data(regs_rd),
    .status_in(dbg_status_in), .ctrl_q(dbg_ctrl_q), .vcatch_q(vcatch_q),
    .wp_flat(wp_cfg)
  );

  dbg_comms #(.VERSION(VERSION)) u_comms (
    .clk(clk), .rst_n(rst_int_n),
    .dbg_wr_en(wr_fire && frm.addr == A_CDAT), .dbg_wr_data(frm.data),
    .dbg_consume(sel_fire && frm.addr == A_CDAT),
    .core_wr_valid(core_wr_valid), .core_wr_data(core_wr_data),
    .core_wr_ready(core_wr_ready), .core_rd_valid(core_rd_valid),
    .core_rd_data(core_rd_data), .core_rd_ack(core_rd_ack),
    .ctrl_word(comms_ctl), .up_word(comms_up)
  );

  always_comb begin
    rd_val = regs_rd;
    if (frm.addr == A_CCTL) rd_val = comms_ctl;
    if (frm.addr == A_CDAT) rd_val = comms_up;
  end

  assign hold_d = rd_val;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    hold_q <= '0;
    else if (sel_fire) hold_q <= hold_d;
  end

  AST_HOLD_ONLY_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sel_fire |=> $stable(hold_q)); // R3
endmodule

// File: tb/dbg_regbank_bench.sv
module dbg_regbank_bench;
  localparam logic [3:0] VER = 4'h6;
  localparam logic [4:0] STAT = 5'h15;

  logic clk = 1'b0;
  logic rst_n, capture_en, shift_en, update_en, tdi, tdo;
  logic [4:0]   dbg_status_in;
  logic [5:0]   dbg_ctrl_q;
  logic [7:0]   vcatch_q;
  logic [383:0] wp_cfg;
  logic         core_wr_valid, core_wr_ready, core_rd_valid, core_rd_ack;
  logic [31:0]  core_wr_data, core_rd_data;

  int total = 0;
  int bad = 0;
  logic [31:0] model [32];

  always #4 clk = ~clk;

  dbg_regbank #(.VERSION(VER)) u_dbg_regbank (
    .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .tdi(tdi), .tdo(tdo), .dbg_status_in(dbg_status_in),
    .dbg_ctrl_q(dbg_ctrl_q), .vcatch_q(vcatch_q), .wp_cfg(wp_cfg),
    .core_wr_valid(core_wr_valid), .core_wr_data(core_wr_data),
    .core_wr_ready(core_wr_ready), .core_rd_valid(core_rd_valid),
    .core_rd_data(core_rd_data), .core_rd_ack(core_rd_ack)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] field_mask(input logic [4:0] a);
    if (a == 5'h00) return 32'h3F;
    if (a == 5'h02) return 32'hFF;
    if ((a[4:3] == 2'b01 || a[4:3] == 2'b10) && a[2:0] < 3'd6)
      return (a[2:0] >= 3'd4) ? 32'h1FF : 32'hFFFF_FFFF;
    return 32'h0;
  endfunction

  function automatic logic [31:0] comms_ctl(input logic pend, input logic rdy);
    return {VER, 26'h0, pend, rdy};
  endfunction

  task automatic scan(input logic wr, input logic [4:0] a, input logic [31:0] d,
                      output logic [37:0] o);
    logic [37:0] v;
    v = {wr, a, d};
    @(negedge clk) capture_en = 1'b1;
    @(negedge clk) capture_en = 1'b0;
    for (int i = 0; i < 38; i++) begin
      shift_en = 1'b1;
      tdi = v[i];
      o[i] = tdo;
      @(negedge clk);
    end
    shift_en = 1'b0;
    update_en = 1'b1;
    @(negedge clk) update_en = 1'b0;
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    logic [37:0] o;
    scan(1'b1, a, d, o);
    model[a] = d & field_mask(a);
  endtask

  task automatic reg_read(input logic [4:0] a, input logic [4:0] next_sel, output logic [37:0] o);
    logic [37:0] dummy;
    scan(1'b0, a, 32'h0, dummy);
    scan(1'b0, next_sel, 32'h0, o);
  endtask

  task automatic core_push(input logic [31:0] d);
    @(negedge clk);
    core_wr_valid = 1'b1;
    core_wr_data = d;
    @(negedge clk) core_wr_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [37:0] o;
    logic [4:0]  a;
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    rst_n = 1'b0; capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0; tdi = 1'b0;
    dbg_status_in = STAT; core_wr_valid = 1'b0; core_wr_data = '0; core_rd_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 tdo", 64'(tdo), 64'h0);
    check("R10 ctrl", 64'(dbg_ctrl_q), 64'h0);
    check("R10 ready", 64'(core_wr_ready), 64'h1);
    check("R10 rd_valid", 64'(core_rd_valid), 64'h0);
    check("R10 wp", 64'(wp_cfg[63:0]), 64'h0);
    scan(1'b0, 5'h00, 32'h0, o);
    check("R10 first capture", 64'(o), 64'h0);

    // R2 R11 debug control write, upper bits dropped
    reg_write(5'h00, 32'hFFFF_FFFF);
    check("R2 ctrl out", 64'(dbg_ctrl_q), 64'h3F);
    reg_read(5'h00, 5'h00, o);
    check("R11 ctrl readback", 64'(o), 64'h3F);
    check("R1 R3 header zero", 64'(o[37:32]), 64'h0);
    reg_write(5'h00, 32'h2F);
    check("R2 monitor bit cleared", 64'(dbg_ctrl_q), 64'h2F);

    // R4 comms control empty
    reg_read(5'h04, 5'h00, o);
    check("R4 comms ctl idle", 64'(o), 64'(comms_ctl(1'b0, 1'b0)));

    // R6 core push, ready flag, blocked second push
    core_push(32'hCAFE_0001);
    check("R6 ready low", 64'(core_wr_ready), 64'h0);
    core_push(32'hDEAD_0002);
    reg_read(5'h04, 5'h00, o);
    check("R4 comms ctl rdy", 64'(o), 64'(comms_ctl(1'b0, 1'b1)));

    // R7 consume and double consume
    scan(1'b0, 5'h05, 32'h0, o);
    check("R7 ready after select", 64'(core_wr_ready), 64'h1);
    core_push(32'hBEEF_0003);
    scan(1'b0, 5'h05, 32'h0, o);
    check("R7 first word R6 blocked ignored", 64'(o), 64'h0000_0000_CAFE_0001);
    check("R7 second consume", 64'(core_wr_ready), 64'h1);
    scan(1'b0, 5'h04, 32'h0, o);
    check("R7 second word", 64'(o), 64'h0000_0000_BEEF_0003);
    scan(1'b0, 5'h00, 32'h0, o);
    check("R7 ctl after consume", 64'(o), 64'(comms_ctl(1'b0, 1'b0)));

    // R5 debugger to core
    reg_write(5'h05, 32'h1234_5678);
    check("R5 rd_valid", 64'(core_rd_valid), 64'h1);
    check("R5 rd_data", 64'(core_rd_data), 64'h1234_5678);
    reg_read(5'h04, 5'h00, o);
    check("R4 pend bit", 64'(o), 64'(comms_ctl(1'b1, 1'b0)));
    @(negedge clk) core_rd_ack = 1'b1;
    @(negedge clk) core_rd_ack = 1'b0;
    check("R5 ack clears", 64'(core_rd_valid), 64'h0);

    // R8 unused and status
    reg_write(5'h02, 32'hFFFF_FF5A);
    check("R11 vcatch width", 64'(vcatch_q), 64'h5A);
    reg_write(5'h03, 32'hFFFF_FFFF);
    model[3] = 32'h0;
    reg_read(5'h03, 5'h00, o);
    check("R8 unused reads zero", 64'(o), 64'h0);
    scan(1'b1, 5'h01, 32'hFFFF_FFFF, o);
    reg_read(5'h01, 5'h00, o);
    check("R8 status ignores write", 64'(o), 64'(STAT));
    reg_read(5'h02, 5'h00, o);
    check("R8 vcatch untouched", 64'(o), 64'h5A);
    reg_read(5'h1F, 5'h00, o);
    check("R8 top address zero", 64'(o), 64'h0);
    check("R8 ctrl untouched", 64'(dbg_ctrl_q), 64'h2F);

    // R9 random register traffic
    for (int n = 0; n < 60; n++) begin
      int r;
      int k;
      r = int'($urandom % 14);
      if (r == 0) a = 5'h00;
      else if (r == 1) a = 5'h02;
      else begin
        k = r - 2;
        a = 5'((k / 6 + 1) * 8 + k % 6);
      end
      d = $urandom;
      reg_write(a, d);
      reg_read(a, 5'h00, o);
      check("R9 R11 readback", 64'(o), 64'(model[a]));
      if (r >= 2) begin
        k = r - 2;
        check("R9 wp_cfg slice", 64'(wp_cfg[k*32 +: 32]), 64'(model[a]));
      end
    end
    // R9 unit 1 last slot versus slot past the unit
    reg_write(5'h15, 32'hFFFF_FFFF);
    reg_read(5'h15, 5'h16, o);
    check("R9 wp1 ctl mask", 64'(o), 64'h1FF);
    scan(1'b0, 5'h00, 32'h0, o);
    check("R8 gap after wp1", 64'(o), 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule